// File: doc/BRIEF.md
# CAN Fault-Confinement Error Counters

This block holds the receive and transmit error counters of a CAN node and derives its fault-confinement state from them. The protocol engine drives it with single-cycle event strobes: receive error, transmit error, good reception and good transmission. While the node is bus off, the engine also sends one strobe for each sampled bus bit, with a flag that marks the bit as recessive. The block raises or lowers the counters for each event, saturates the receive counter at the passive limit and pulls it back below that limit after a good frame. It then reports whether the node is error active, error passive or bus off.

In the bus-off state the receive counter is reused as a recovery timer. Each group of eleven consecutive recessive bits advances it by one. When it reaches the passive limit, the node returns to error active with both counters at zero. A CPU register port reads both counters as one word. Software can load the counters only while test-error mode is on. Holding the configuration-mode input high keeps both counters at zero.

The state machine has three states. ACTIVE moves to PASSIVE once either counter is at least 128 ("go passive"). PASSIVE returns to ACTIVE once both counters are below 128 ("recover active"). ACTIVE or PASSIVE moves to BUSOFF when the transmit counter exceeds 255 ("go bus off"). BUSOFF returns to ACTIVE on recovery ("bus-off recovery"). Configuration mode forces any state to ACTIVE ("config reset").

Top module: `can_fault_counters`

## Requirements
- R1: `reg_rdata_o` returns the receive counter in bits 7:0 and the transmit counter in bits 15:8. Bits 31:16 read zero.
- R2: A register write with `test_err_i` low changes neither counter.
- R3: A register write with `test_err_i` high and configuration mode off loads bits 7:0 of the write data into both counters, one cycle later. Bits 15:8 of the write data are ignored. In that cycle the write overrides any event strobe.
- R4: A receive error adds 1 to a receive counter below 128. At 128 or above, the counter holds. If `rx_err_i` and `rx_ok_i` are both high, the error wins.
- R5: A good reception sets a receive counter of 128 or more to 127. Otherwise it subtracts 1, and a counter at 0 stays at 0.
- R6: A transmit error adds 8 to the transmit counter. A good transmission subtracts 1 and stops at 0. If both strobes are high, the error wins.
- R7: `fc_state_o` encodes 0 as active, 1 as passive and 2 as bus off. Outside bus off, it reads 1 in the same cycle that either counter is at least 128, and 0 otherwise.
- R8: A transmit counter above 255 makes the state 2 (bus off). Entering bus off clears the receive counter and the recessive-run count. While in bus off, the four protocol strobes have no effect.
- R9: In bus off, every eleventh consecutive recessive bit strobe adds 1 to the receive counter. A dominant bit strobe restarts the run. Cycles without a bit strobe do not break the run.
- R10: When the receive counter reaches 128 in bus off, the state becomes 0 and both counters read 0. Starting from bus-off entry, this takes exactly 1408 recessive bits.
- R11: While `cfg_mode_i` is high, both counters are held at 0 and the state at 0. Writes and strobes are ignored.
- R12: After reset both counters are 0 and the state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | Configuration mode; clears and holds the counters |
| test_err_i | input | 1 | Test-error mode; enables register writes |
| rx_err_i | input | 1 | Receive error strobe |
| rx_ok_i | input | 1 | Good reception strobe |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_ok_i | input | 1 | Good transmission strobe |
| bit_valid_i | input | 1 | One strobe for each sampled bus bit |
| bit_recessive_i | input | 1 | Level of the strobed bit, 1 = recessive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| rx_cnt_o | output | 8 | Receive error counter |
| tx_cnt_o | output | 8 | Transmit error counter, low 8 bits |
| fc_state_o | output | 2 | Fault-confinement state |

## Verification
A table of single strobes moves the counters through the normal range, the decrement floor at zero, the 127-to-128 passive crossing, saturation at 128 and the fallback to 127. Together these separate the increment, hold and fallback branches. Accepted and refused writes are placed between the strobes, so any leak of a refused write, or of write bits 15:8, shows up in later rows. Directed patterns then pair conflicting strobes, and pair a write with strobes, to expose the priority order. The bus-off recovery is driven with an early dominant bit, idle gaps and ignored protocol strobes. It is checked one bit before and exactly at bit 1408, which catches a run that fails to restart, a missing clear on entry and strobes that leak into bus off. Configuration mode is applied both in passive and in bus off.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_recessive_run.sv
// Counts consecutive recessive bit strobes while armed and pulses on each full group.
module fc_recessive_run #(
    parameter int RUN_LEN = 11
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic armed_i,
    input  logic bit_valid_i,
    input  logic bit_recessive_i,
    output logic group_done_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

    logic [RUN_W-1:0] run_q, run_d;
    logic             done;

    always_comb begin
        run_d = run_q;
        done  = 1'b0;
        if (!armed_i) begin
            run_d = '0;
        end else if (bit_valid_i) begin
            if (!bit_recessive_i) begin
                run_d = '0;
            end else if (run_q == RUN_LAST) begin
                run_d = '0;
                done  = 1'b1;
            end else begin
                run_d = run_q + RUN_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= '0;
        else         run_q <= run_d;
    end

    assign group_done_o = done;

    AST_DOMINANT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_valid_i && !bit_recessive_i) |=> (run_q == '0)); // R9
    AST_IDLE_HOLDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_i && !bit_valid_i) |=> $stable(run_q)); // R9
endmodule

// File: rtl/fc_rx_counter.sv
// Receive error counter, doubling as the bus-off recovery timer.
module fc_rx_counter #(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LIM = 128,
    parameter int FALLBACK    = 127
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             in_busoff_i,
    input  logic             enter_bo_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    input  logic             group_done_i,
    output logic [CNT_W-1:0] rx_q_o,
    output logic [CNT_W-1:0] rx_nxt_o,
    output logic             recover_o
);
    localparam logic [CNT_W-1:0] LIM_C    = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] LIM_M1_C = CNT_W'(PASSIVE_LIM - 1);
    localparam logic [CNT_W-1:0] FALL_C   = CNT_W'(FALLBACK);
    localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

    logic [CNT_W-1:0] rx_q, rx_d;
    logic             recover;

    always_comb begin
        rx_d    = rx_q;
        recover = 1'b0;
        if (cfg_i) begin
            rx_d = '0;
        end else if (wr_i) begin
            rx_d = wr_val_i;
        end else if (in_busoff_i) begin
            if (group_done_i) begin
                if (rx_q >= LIM_M1_C) begin
                    recover = 1'b1;
                    rx_d    = '0;
                end else begin
                    rx_d = rx_q + ONE_C;
                end
            end
        end else if (enter_bo_i) begin
            rx_d = '0;
        end else if (rx_err_i) begin
            if (rx_q < LIM_C) rx_d = rx_q + ONE_C;
        end else if (rx_ok_i) begin
            if (rx_q >= LIM_C)     rx_d = FALL_C;
            else if (rx_q != '0)   rx_d = rx_q - ONE_C;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rx_q <= '0;
        else         rx_q <= rx_d;
    end

    assign rx_q_o    = rx_q;
    assign rx_nxt_o  = rx_d;
    assign recover_o = recover;

    AST_RX_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_i && !wr_i && !in_busoff_i && !enter_bo_i && rx_err_i && rx_q >= LIM_C)
        |=> (rx_q == $past(rx_q))); // R4
    AST_RX_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_i && !wr_i && !in_busoff_i && !enter_bo_i && !rx_err_i && rx_ok_i && rx_q >= LIM_C)
        |=> (rx_q == FALL_C)); // R5
    AST_RX_CFG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_i |=> (rx_q == '0)); // R11
endmodule

// File: rtl/fc_tx_counter.sv
// Transmit error counter, one bit wider than the visible value so overflow past the top is seen.
module fc_tx_counter #(
    parameter int CNT_W    = 8,
    parameter int ERR_STEP = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           cfg_i,
    input  logic           wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic           in_busoff_i,
    input  logic           recover_i,
    input  logic           tx_err_i,
    input  logic           tx_ok_i,
    output logic [CNT_W:0] tx_q_o,
    output logic [CNT_W:0] tx_nxt_o
);
    localparam int TX_W = CNT_W + 1;
    localparam logic [TX_W-1:0] STEP_C = TX_W'(ERR_STEP);
    localparam logic [TX_W-1:0] ONE_C  = TX_W'(1);

    logic [TX_W-1:0] tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        if (cfg_i) begin
            tx_d = '0;
        end else if (wr_i) begin
            tx_d = {1'b0, wr_val_i};
        end else if (in_busoff_i) begin
            if (recover_i) tx_d = '0;
        end else if (tx_err_i) begin
            tx_d = tx_q + STEP_C;
        end else if (tx_ok_i) begin
            if (tx_q != '0) tx_d = tx_q - ONE_C;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tx_q <= '0;
        else         tx_q <= tx_d;
    end

    assign tx_q_o   = tx_q;
    assign tx_nxt_o = tx_d;

    AST_TX_ERR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_i && !wr_i && !in_busoff_i && tx_err_i) |=> (tx_q == $past(tx_q) + STEP_C)); // R6
    AST_TX_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_i && !wr_i && !in_busoff_i && !tx_err_i && tx_ok_i && tx_q == '0) |=> (tx_q == '0)); // R6
endmodule

// File: rtl/fc_state_fsm.sv
// Fault-confinement state register: ACTIVE, PASSIVE, BUSOFF.
module fc_state_fsm
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LIM = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_i,
    input  logic             recover_i,
    input  logic [CNT_W-1:0] rx_nxt_i,
    input  logic [CNT_W:0]   tx_nxt_i,
    output fc_state_e        state_o,
    output logic             in_busoff_o,
    output logic             enter_bo_o
);
    localparam logic [CNT_W-1:0] RX_LIM_C = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W:0]   TX_LIM_C = (CNT_W+1)'(PASSIVE_LIM);
    localparam logic [CNT_W:0]   TX_TOP_C = (CNT_W+1)'((1 << CNT_W) - 1);

    fc_state_e state_q, state_d;
    logic      over_top, any_passive;

    assign over_top    = (tx_nxt_i > TX_TOP_C);
    assign any_passive = (rx_nxt_i >= RX_LIM_C) || (tx_nxt_i >= TX_LIM_C);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE: begin
                if (cfg_i)            state_d = FC_ACTIVE;
                else if (over_top)    state_d = FC_BUSOFF;
                else if (any_passive) state_d = FC_PASSIVE;
                else                  state_d = FC_ACTIVE;
            end
            FC_PASSIVE: begin
                if (cfg_i)            state_d = FC_ACTIVE;
                else if (over_top)    state_d = FC_BUSOFF;
                else if (any_passive) state_d = FC_PASSIVE;
                else                  state_d = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (cfg_i || recover_i) state_d = FC_ACTIVE;
                else                    state_d = FC_BUSOFF;
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= FC_ACTIVE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        state_o     = state_q;
        in_busoff_o = (state_q == FC_BUSOFF);
        enter_bo_o  = (state_q != FC_BUSOFF) && !cfg_i && over_top;
    end

    AST_BUSOFF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FC_BUSOFF && !cfg_i && !recover_i) |=> (state_q == FC_BUSOFF)); // R8
    AST_RECOVER_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FC_BUSOFF && recover_i) |=> (state_q == FC_ACTIVE)); // R10
    AST_CFG_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_i |=> (state_q == FC_ACTIVE)); // R11
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int REG_W       = 32,
    parameter int PASSIVE_LIM = 128,
    parameter int RX_FALLBACK = 127,
    parameter int TX_ERR_STEP = 8,
    parameter int RUN_LEN     = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_mode_i,
    input  logic             test_err_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             bit_valid_i,
    input  logic             bit_recessive_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic [CNT_W-1:0] rx_cnt_o,
    output logic [CNT_W-1:0] tx_cnt_o,
    output logic [1:0]       fc_state_o
);
    localparam int TX_W = CNT_W + 1;

    logic             wr_acc;
    logic [CNT_W-1:0] wr_val;
    logic [CNT_W-1:0] rx_q, rx_nxt;
    logic [TX_W-1:0]  tx_q, tx_nxt;
    logic             recover, in_busoff, enter_bo, group_done;
    fc_state_e        state;
    logic             unused_bits;

    assign wr_acc      = reg_wr_i && test_err_i && !cfg_mode_i;
    assign wr_val      = reg_wdata_i[CNT_W-1:0];
    assign unused_bits = ^{reg_wdata_i[REG_W-1:CNT_W], tx_q[CNT_W]};

    fc_recessive_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .armed_i        (in_busoff && !cfg_mode_i),
        .bit_valid_i    (bit_valid_i),
        .bit_recessive_i(bit_recessive_i),
        .group_done_o   (group_done)
    );

    fc_rx_counter #(
        .CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM), .FALLBACK(RX_FALLBACK)
    ) u_rx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_i       (cfg_mode_i),
        .wr_i        (wr_acc),
        .wr_val_i    (wr_val),
        .in_busoff_i (in_busoff),
        .enter_bo_i  (enter_bo),
        .rx_err_i    (rx_err_i),
        .rx_ok_i     (rx_ok_i),
        .group_done_i(group_done),
        .rx_q_o      (rx_q),
        .rx_nxt_o    (rx_nxt),
        .recover_o   (recover)
    );

    fc_tx_counter #(.CNT_W(CNT_W), .ERR_STEP(TX_ERR_STEP)) u_tx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (cfg_mode_i),
        .wr_i       (wr_acc),
        .wr_val_i   (wr_val),
        .in_busoff_i(in_busoff),
        .recover_i  (recover),
        .tx_err_i   (tx_err_i),
        .tx_ok_i    (tx_ok_i),
        .tx_q_o     (tx_q),
        .tx_nxt_o   (tx_nxt)
    );

    fc_state_fsm #(.CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (cfg_mode_i),
        .recover_i  (recover),
        .rx_nxt_i   (rx_nxt),
        .tx_nxt_i   (tx_nxt),
        .state_o    (state),
        .in_busoff_o(in_busoff),
        .enter_bo_o (enter_bo)
    );

    assign rx_cnt_o    = rx_q;
    assign tx_cnt_o    = tx_q[CNT_W-1:0];
    assign fc_state_o  = state;
    assign reg_rdata_o = REG_W'({tx_q[CNT_W-1:0], rx_q});

    AST_WRITE_LOADS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && test_err_i && !cfg_mode_i)
        |=> (rx_cnt_o == $past(reg_wdata_i[CNT_W-1:0]) && tx_cnt_o == $past(reg_wdata_i[CNT_W-1:0]))); // R3
    AST_WRITE_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !test_err_i && !cfg_mode_i && !rx_err_i && !rx_ok_i && !tx_err_i && !tx_ok_i
         && fc_state_o != 2'd2) |=> $stable(reg_rdata_o)); // R2
endmodule

// File: tb/tb_can_fault_counters.sv
`timescale 1ns/1ps
module tb_can_fault_counters;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg = 1'b0, te = 1'b0, rxe = 1'b0, rxo = 1'b0, txe = 1'b0, txo = 1'b0;
    logic        bv = 1'b0, br = 1'b0, wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic [7:0]  rxc, txc;
    logic [1:0]  st;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    can_fault_counters dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg), .test_err_i(te),
        .rx_err_i(rxe), .rx_ok_i(rxo), .tx_err_i(txe), .tx_ok_i(txo),
        .bit_valid_i(bv), .bit_recessive_i(br), .reg_wr_i(wr), .reg_wdata_i(wd),
        .reg_rdata_o(rd), .rx_cnt_o(rxc), .tx_cnt_o(txc), .fc_state_o(st)
    );

    localparam logic [2:0] OP_RXE = 3'd1, OP_RXO = 3'd2, OP_TXE = 3'd3, OP_TXO = 3'd4,
                           OP_WR = 3'd5, OP_WRN = 3'd6;
    typedef struct packed {
        logic [2:0] op;
        logic [7:0] dat;
        logic [7:0] erx;
        logic [7:0] etx;
        logic [1:0] est;
    } vec_t;
    localparam int NV = 18;
    localparam vec_t VECS [0:NV-1] = '{
        {OP_RXE, 8'd0,   8'd1,   8'd0,   2'd0},
        {OP_RXO, 8'd0,   8'd0,   8'd0,   2'd0},
        {OP_RXO, 8'd0,   8'd0,   8'd0,   2'd0},
        {OP_TXO, 8'd0,   8'd0,   8'd0,   2'd0},
        {OP_TXE, 8'd0,   8'd0,   8'd8,   2'd0},
        {OP_TXO, 8'd0,   8'd0,   8'd7,   2'd0},
        {OP_WR,  8'd126, 8'd126, 8'd126, 2'd0},
        {OP_WRN, 8'd5,   8'd126, 8'd126, 2'd0},
        {OP_RXE, 8'd0,   8'd127, 8'd126, 2'd0},
        {OP_RXE, 8'd0,   8'd128, 8'd126, 2'd1},
        {OP_RXE, 8'd0,   8'd128, 8'd126, 2'd1},
        {OP_RXO, 8'd0,   8'd127, 8'd126, 2'd0},
        {OP_TXE, 8'd0,   8'd127, 8'd134, 2'd1},
        {OP_TXO, 8'd0,   8'd127, 8'd133, 2'd1},
        {OP_WR,  8'd0,   8'd0,   8'd0,   2'd0},
        {OP_WR,  8'd250, 8'd250, 8'd250, 2'd1},
        {OP_RXE, 8'd0,   8'd250, 8'd250, 2'd1},
        {OP_RXO, 8'd0,   8'd127, 8'd250, 2'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        {cfg, te, rxe, rxo, txe, txo, bv, br, wr} = '0;
        wd = '0;
    endtask

    task automatic do_write(input logic [7:0] v);
        wr = 1'b1; te = 1'b1; wd = {16'hFFFF, ~v, v};
        tick();
    endtask

    task automatic send_bit(input logic rec);
        bv = 1'b1; br = rec;
        tick();
    endtask

    task automatic check_cnt(input string req, input logic [7:0] erx, input logic [7:0] etx,
                             input logic [1:0] est);
        check({req, " rx"}, {24'd0, rxc}, {24'd0, erx});
        check({req, " tx"}, {24'd0, txc}, {24'd0, etx});
        check({req, " state"}, {30'd0, st}, {30'd0, est});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R12 actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 rdata", rd, 32'd0);
        check("R12 state", {30'd0, st}, 32'd0);

        // Vector table: R1..R7
        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_RXE: rxe = 1'b1;
                OP_RXO: rxo = 1'b1;
                OP_TXE: txe = 1'b1;
                OP_TXO: txo = 1'b1;
                OP_WR:  begin wr = 1'b1; te = 1'b1; wd = {16'hFFFF, ~VECS[i].dat, VECS[i].dat}; end
                OP_WRN: begin wr = 1'b1; te = 1'b0; wd = {16'h0000, 8'h00, VECS[i].dat}; end
                default: ;
            endcase
            tick();
            check_cnt($sformatf("R2_R3_R4_R5_R6_R7 vec%0d", i), VECS[i].erx, VECS[i].etx, VECS[i].est);
            check("R1 rdata", rd, {16'd0, VECS[i].etx, VECS[i].erx});
        end

        // Priority corners
        do_write(8'd10);
        check_cnt("R3 load", 8'd10, 8'd10, 2'd0);
        rxe = 1'b1; rxo = 1'b1; tick();
        check("R4 err beats ok", {24'd0, rxc}, 32'd11);
        txe = 1'b1; txo = 1'b1; tick();
        check("R6 err beats ok", {24'd0, txc}, 32'd18);
        wr = 1'b1; te = 1'b1; wd = {16'h0, 8'h99, 8'd40}; rxe = 1'b1; txe = 1'b1; tick();
        check_cnt("R3 write beats strobes", 8'd40, 8'd40, 2'd0);

        // Bus off entry, ignored strobes, recovery timing
        do_write(8'd250);
        txe = 1'b1; tick();
        check("R8 enter bus off", {30'd0, st}, 32'd2);
        rxe = 1'b1; tick();
        rxo = 1'b1; tick();
        txo = 1'b1; tick();
        txe = 1'b1; tick();
        check("R8 strobes ignored state", {30'd0, st}, 32'd2);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_bit(1'b0);
        rxe = 1'b1; tick();
        for (int i = 0; i < 1407; i++) begin
            send_bit(1'b1);
            if (i % 97 == 0) tick();
        end
        check("R9 one bit short", {30'd0, st}, 32'd2);
        send_bit(1'b1);
        check_cnt("R10 recovered", 8'd0, 8'd0, 2'd0);

        // Configuration mode
        do_write(8'd200);
        check("R7 passive by write", {30'd0, st}, 32'd1);
        cfg = 1'b1; rxe = 1'b1; wr = 1'b1; te = 1'b1; wd = 32'd50; tick();
        check_cnt("R11 cfg clears", 8'd0, 8'd0, 2'd0);
        cfg = 1'b1; txe = 1'b1; tick();
        check_cnt("R11 cfg holds", 8'd0, 8'd0, 2'd0);
        tick();
        check_cnt("R11 after cfg", 8'd0, 8'd0, 2'd0);
        do_write(8'd255);
        txe = 1'b1; tick();
        check("R8 bus off again", {30'd0, st}, 32'd2);
        cfg = 1'b1; tick();
        check_cnt("R11 cfg leaves bus off", 8'd0, 8'd0, 2'd0);
        check("R1 upper zero", rd, 32'd0);

        finish_run();
    end
endmodule